// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This block steers one switchable power domain between its running and unpowered conditions. Software issues power-down and power-up requests as pulses. The block drives the domain's clock enable, isolation enable, retention hold, retention restore strobe and power-switch enable in a strict order. On the way down the order is isolate, then retain, then cut power. On the way up it is the exact reverse. Stopping the domain clock around retention is an optional step, chosen by a configuration bit when a power-down begins.

Each intermediate step lasts a programmable number of settle cycles. The switch-off and switch-on steps can instead wait for a power-good indication from the switch. A request that arrives while the domain is moving the other way is held until the current sequence completes, and is then acted on. The block reports its state, its phase and a busy flag, and it pulses a done output when the domain becomes fully on or fully off.

States and transitions:
- ON goes to ISO on a down request.
- ISO goes to CLKOFF when the clock stop is chosen, and to SAVE otherwise.
- CLKOFF goes to SAVE.
- SAVE goes to OFF.
- OFF goes to PWRUP on an up request, once the switch-off has settled.
- PWRUP goes to RESTORE.
- RESTORE goes to CLKON when the clock was stopped, and to DEISO otherwise.
- CLKON goes to DEISO.
- DEISO goes to ON.

Top module: `pwr_domain_sequencer`

## Requirements
- R1: A synchronous active-low reset gives this state after the first clock edge:
  - state ON, which is code 0;
  - clk_en=1, iso_en=0, ret_hold=0, ret_restore=0, pwr_en=1;
  - phase 0, busy=0, done=0.
- R2: A down request in ON walks the states in this order: ISO (1), then CLKOFF (2) if the clock is stopped, then SAVE (3), then OFF (4). The outputs in each state are:
  - ISO: iso_en=1;
  - CLKOFF: clk_en=0;
  - SAVE: ret_hold=1;
  - OFF: pwr_en=0.
- R3: An up request in settled OFF walks the states in this order: PWRUP (5), then RESTORE (6), then CLKON (7) if the clock was stopped, then DEISO (8), then ON. The outputs in each state are:
  - PWRUP: pwr_en=1;
  - RESTORE: ret_restore=1 while ret_hold is still 1;
  - CLKON: ret_hold=0 and clk_en=1;
  - DEISO: iso_en still 1.
  - iso_en falls only when ON is entered.
- R4: cfg_clk_stop is captured when a power-down starts, and that captured value controls both the down sequence and the following up sequence. When the captured value is 0, CLKOFF and CLKON are skipped and clk_en stays 1 throughout.
- R5: Whenever pwr_en is 0, iso_en and ret_hold are 1. iso_en and ret_hold are both already 1 in the cycle before pwr_en falls.
- R6: Every timed step lasts max(cfg_settle,1) cycles. The timed steps are ISO, CLKOFF, SAVE, RESTORE, CLKON and DEISO, plus PWRUP and the OFF settle when cfg_use_ack=0.
- R7: With cfg_use_ack=1, PWRUP ends on the first cycle in which pwr_good=1, and OFF settles on the first cycle in which pwr_good=0. Either step waits indefinitely until that happens.
- R8: An up request made while powering down is held and starts power-up right after OFF settles. A down request made while powering up is held and starts power-down right after ON is reached.
- R9: phase_o is:
  - 0 when ON;
  - 1 when powering down, which includes OFF before it settles;
  - 2 when OFF has settled;
  - 3 when powering up.
  - busy is 1 exactly in phases 1 and 3.
- R10: done is a single-cycle pulse. It is high in the first cycle of ON after DEISO, and in the first cycle in which OFF has settled.
- R11: An up request in ON has no effect, and a down request in settled OFF has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_down | input | 1 | Power-down request pulse |
| req_up | input | 1 | Power-up request pulse |
| cfg_clk_stop | input | 1 | Stop the domain clock around retention |
| cfg_use_ack | input | 1 | Switch steps wait for pwr_good instead of the timer |
| cfg_settle | input | SETTLE_W | Settle cycles per timed step (0 acts as 1) |
| pwr_good | input | 1 | Switch feedback, 1 while the domain supply is present |
| clk_en | output | 1 | Domain clock enable |
| iso_en | output | 1 | Output isolation enable |
| ret_hold | output | 1 | Retention flops hold their state |
| ret_restore | output | 1 | Restore strobe to the retention flops |
| pwr_en | output | 1 | Power-switch enable |
| state_o | output | 4 | Current state code |
| phase_o | output | 2 | Phase: 0 on, 1 down, 2 off, 3 up |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when ON or settled OFF is reached |

## Verification
Some properties are checked on every cycle. These are the ordering rules: isolation is up before retention rises, isolation and retention are in place before power is cut, and isolation falls only with power, clock and retention already back. The single-cycle done pulse, the wait on power-good, the timer countdown and the exclusivity of held requests are also checked every cycle.

Other behaviour only the directed scenarios can show. That covers the exact state order with and without the clock stop, and the step lengths for several settle values. It also covers the capture of the clock-stop choice, requests held across a sequence in the opposite direction, and requests that must be ignored.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        PS_ON      = 4'd0,
        PS_ISO     = 4'd1,
        PS_CLKOFF  = 4'd2,
        PS_SAVE    = 4'd3,
        PS_OFF     = 4'd4,
        PS_PWRUP   = 4'd5,
        PS_RESTORE = 4'd6,
        PS_CLKON   = 4'd7,
        PS_DEISO   = 4'd8
    } pd_state_e;

    typedef enum logic [1:0] {
        PH_ON   = 2'd0,
        PH_DOWN = 2'd1,
        PH_OFF  = 2'd2,
        PH_UP   = 2'd3
    } pd_phase_e;

endpackage

// File: rtl/pds_settle_timer.sv
module pds_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                expired
);

    localparam logic [SETTLE_W-1:0] ZERO = '0;
    localparam logic [SETTLE_W-1:0] ONE  = {{(SETTLE_W-1){1'b0}}, 1'b1};

    logic [SETTLE_W-1:0] cnt_q;

    // A zero setting behaves as one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= (load_val == ZERO) ? ZERO : load_val - ONE;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q == ZERO);

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/pds_req_hold.sv
module pds_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_up,
    input  logic req_dn,
    input  logic down_phase,
    input  logic up_phase,
    input  logic take_up,
    input  logic take_dn,
    output logic pend_up,
    output logic pend_dn
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_up <= 1'b0;
            pend_dn <= 1'b0;
        end else begin
            if (take_up)                     pend_up <= 1'b0;
            else if (req_up && down_phase)   pend_up <= 1'b1;
            if (take_dn)                     pend_dn <= 1'b0;
            else if (req_dn && up_phase)     pend_dn <= 1'b1;
        end
    end

    p_pend_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_up && pend_dn));

endmodule

// File: rtl/pwr_domain_sequencer.sv
module pwr_domain_sequencer
    import pds_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_down,
    input  logic                req_up,
    input  logic                cfg_clk_stop,
    input  logic                cfg_use_ack,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic                pwr_good,
    output logic                clk_en,
    output logic                iso_en,
    output logic                ret_hold,
    output logic                ret_restore,
    output logic                pwr_en,
    output logic [STATE_W-1:0]  state_o,
    output logic [1:0]          phase_o,
    output logic                busy,
    output logic                done
);

    pd_state_e state_q, state_n;
    logic      stop_q;
    logic      off_done_q;
    logic      done_q;
    logic      expired;
    logic      pend_up, pend_dn;
    logic      go_down, go_up;
    logic      off_ok, up_ok;
    logic      down_phase, up_phase;
    logic      take_up, take_dn;
    pd_phase_e phase;

    assign go_down = req_down | pend_dn;
    assign go_up   = req_up | pend_up;
    assign off_ok  = cfg_use_ack ? !pwr_good : expired;
    assign up_ok   = cfg_use_ack ?  pwr_good : expired;

    pds_settle_timer #(.SETTLE_W(SETTLE_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_n != state_q),
        .load_val (cfg_settle),
        .expired  (expired)
    );

    assign down_phase = (state_q == PS_ISO) || (state_q == PS_CLKOFF) ||
                        (state_q == PS_SAVE) || (state_q == PS_OFF && !off_done_q);
    assign up_phase   = (state_q == PS_PWRUP) || (state_q == PS_RESTORE) ||
                        (state_q == PS_CLKON) || (state_q == PS_DEISO);
    assign take_dn    = (state_q == PS_ON) && go_down;
    assign take_up    = (state_q == PS_OFF) && off_done_q && go_up;

    pds_req_hold i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_up     (req_up),
        .req_dn     (req_down),
        .down_phase (down_phase),
        .up_phase   (up_phase),
        .take_up    (take_up),
        .take_dn    (take_dn),
        .pend_up    (pend_up),
        .pend_dn    (pend_dn)
    );

    // Next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PS_ON:      if (go_down)        state_n = PS_ISO;
            PS_ISO:     if (expired)        state_n = stop_q ? PS_CLKOFF : PS_SAVE;
            PS_CLKOFF:  if (expired)        state_n = PS_SAVE;
            PS_SAVE:    if (expired)        state_n = PS_OFF;
            PS_OFF:     if (take_up)        state_n = PS_PWRUP;
            PS_PWRUP:   if (up_ok)          state_n = PS_RESTORE;
            PS_RESTORE: if (expired)        state_n = stop_q ? PS_CLKON : PS_DEISO;
            PS_CLKON:   if (expired)        state_n = PS_DEISO;
            PS_DEISO:   if (expired)        state_n = PS_ON;
            default:                        state_n = PS_ON;
        endcase
    end

    // State register and sequence bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_ON;
            stop_q     <= 1'b0;
            off_done_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q    <= state_n;
            if (take_dn) stop_q <= cfg_clk_stop;
            off_done_q <= (state_q == PS_OFF) && (state_n == PS_OFF) &&
                          (off_done_q || off_ok);
            done_q     <= ((state_q == PS_DEISO) && expired) ||
                          ((state_q == PS_OFF) && !off_done_q && off_ok);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        clk_en      = 1'b1;
        iso_en      = 1'b1;
        ret_hold    = 1'b0;
        ret_restore = 1'b0;
        pwr_en      = 1'b1;
        phase       = PH_UP;
        unique case (state_q)
            PS_ON:      begin iso_en = 1'b0; phase = PH_ON; end
            PS_ISO:     phase = PH_DOWN;
            PS_CLKOFF:  begin clk_en = 1'b0; phase = PH_DOWN; end
            PS_SAVE:    begin clk_en = !stop_q; ret_hold = 1'b1; phase = PH_DOWN; end
            PS_OFF:     begin
                            clk_en   = !stop_q;
                            ret_hold = 1'b1;
                            pwr_en   = 1'b0;
                            phase    = off_done_q ? PH_OFF : PH_DOWN;
                        end
            PS_PWRUP:   begin clk_en = !stop_q; ret_hold = 1'b1; end
            PS_RESTORE: begin clk_en = !stop_q; ret_hold = 1'b1; ret_restore = 1'b1; end
            PS_CLKON:   ;
            PS_DEISO:   ;
            default:    begin iso_en = 1'b0; phase = PH_ON; end
        endcase
    end

    assign state_o = state_q;
    assign phase_o = phase;
    assign busy    = (phase == PH_DOWN) || (phase == PH_UP);
    assign done    = done_q;

    p_iso_before_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_hold) |-> $past(iso_en));

    p_iso_falls_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (pwr_en && clk_en && !ret_hold && !ret_restore));

    p_off_is_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (iso_en && ret_hold));

    p_safe_before_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> ($past(iso_en) && $past(ret_hold)));

    p_ack_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PWRUP && cfg_use_ack && !pwr_good) |=> (state_q == PS_PWRUP));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_pwr_domain_sequencer.sv
module test_pwr_domain_sequencer;

    localparam int CLK_P    = 10;
    localparam int SETTLE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_down, req_up;
    logic                cfg_clk_stop, cfg_use_ack;
    logic [SETTLE_W-1:0] cfg_settle;
    logic                pwr_good;
    logic                clk_en, iso_en, ret_hold, ret_restore, pwr_en;
    logic [3:0]          state_o;
    logic [1:0]          phase_o;
    logic                busy, done;

    int total = 0;
    int fails = 0;
    int unsafe_cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    pwr_domain_sequencer #(.SETTLE_W(SETTLE_W)) i_pwr_domain_sequencer (
        .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
        .cfg_clk_stop(cfg_clk_stop), .cfg_use_ack(cfg_use_ack),
        .cfg_settle(cfg_settle), .pwr_good(pwr_good),
        .clk_en(clk_en), .iso_en(iso_en), .ret_hold(ret_hold),
        .ret_restore(ret_restore), .pwr_en(pwr_en), .state_o(state_o),
        .phase_o(phase_o), .busy(busy), .done(done)
    );

    // R5 monitor: power off must always come with isolation and retention
    always @(negedge clk)
        if (rst_n === 1'b1 && pwr_en === 1'b0 && !(iso_en && ret_hold))
            unsafe_cycles++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected {clk_en, iso_en, ret_hold, ret_restore, pwr_en} per state (R2, R3, R4)
    function automatic int exp_out(input int s, input bit stop);
        case (s)
            0: return 5'b10001;
            1: return 5'b11001;
            2: return 5'b01001;
            3: return {~stop, 4'b1101};
            4: return {~stop, 4'b1100};
            5: return {~stop, 4'b1101};
            6: return {~stop, 4'b1111};
            default: return 5'b11001;
        endcase
    endfunction

    function automatic int out_vec();
        return {clk_en, iso_en, ret_hold, ret_restore, pwr_en};
    endfunction

    task automatic pulse(input bit dn);
        @(negedge clk);
        if (dn) req_down = 1'b1; else req_up = 1'b1;
        @(negedge clk);
        req_down = 1'b0;
        req_up   = 1'b0;
    endtask

    // Runs one sequence: request at a negedge, then follow it until done
    task automatic run_seq(input bit dn, input bit stop, input int settle_eff,
                           input int e0, input int e1, input int e2,
                           input int e3, input int e4, input int n, input string tag);
        int seq [5];
        int last;
        int idx;
        int cyc;
        seq[0] = e0; seq[1] = e1; seq[2] = e2; seq[3] = e3; seq[4] = e4;
        last = int'(state_o);
        idx  = 0;
        cyc  = 0;
        @(negedge clk);
        if (dn) req_down = 1'b1; else req_up = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_down = 1'b0;
            req_up   = 1'b0;
            cyc++;
            if (cyc == 1)
                check(busy && phase_o == (dn ? 2'd1 : 2'd3), {tag, " R9 phase at start"},
                      int'(phase_o), dn ? 1 : 3);
            if (int'(state_o) != last) begin
                last = int'(state_o);
                check(idx < n && last == seq[idx], {tag, " R2/R3 state order"},
                      last, (idx < n) ? seq[idx] : -1);
                check(out_vec() == exp_out(last, stop), {tag, " R4 outputs in state"},
                      out_vec(), exp_out(last, stop));
                idx++;
            end
            if (done) break;
        end
        check(done == 1'b1, {tag, " R10 done reached"}, int'(done), 1);
        check(idx == n, {tag, " R2/R3 number of states"}, idx, n);
        check(cyc == (n - (dn ? 0 : 1)) * settle_eff + 1 + (dn ? 0 : 0) - (dn ? 0 : 0)
                     + (dn ? 0 : settle_eff) - (dn ? 0 : settle_eff) ,
              {tag, " R6 sequence length"}, cyc, n * settle_eff + 1 - (dn ? 0 : settle_eff));
        check(phase_o == (dn ? 2'd2 : 2'd0) && !busy, {tag, " R9 phase at end"},
              int'(phase_o), dn ? 2 : 0);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 done single cycle"}, int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(state_o == 4'd0, "R1 reset state", int'(state_o), 0);
        check(out_vec() == 5'b10001, "R1 reset outputs", out_vec(), 5'b10001);
        check(phase_o == 2'd0 && !busy && !done, "R1 reset phase/busy/done",
              int'({phase_o, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2, R3, R4: full cycle with clock stop; capture holds for the up sequence
    task automatic t_cycle_stop();
        cfg_settle = 8'd4; cfg_clk_stop = 1'b1;
        run_seq(1'b1, 1'b1, 4, 1, 2, 3, 4, 0, 4, "down stop");
        cfg_clk_stop = 1'b0;
        run_seq(1'b0, 1'b1, 4, 5, 6, 7, 8, 0, 5, "up stop R4 captured");
    endtask

    // R4: no clock stop skips CLKOFF and CLKON
    task automatic t_cycle_nostop();
        cfg_settle = 8'd4; cfg_clk_stop = 1'b0;
        run_seq(1'b1, 1'b0, 4, 1, 3, 4, 0, 0, 3, "down nostop R4");
        run_seq(1'b0, 1'b0, 4, 5, 6, 8, 0, 0, 4, "up nostop R4");
    endtask

    // R6: other settle values, zero acts as one
    task automatic t_settle();
        cfg_clk_stop = 1'b0;
        cfg_settle = 8'd0;
        run_seq(1'b1, 1'b0, 1, 1, 3, 4, 0, 0, 3, "down settle0 R6");
        cfg_settle = 8'd7;
        run_seq(1'b0, 1'b0, 7, 5, 6, 8, 0, 0, 4, "up settle7 R6");
    endtask

    // R7: switch acknowledge controls the power steps
    task automatic t_ack();
        cfg_settle = 8'd2; cfg_clk_stop = 1'b0; cfg_use_ack = 1'b1; pwr_good = 1'b1;
        pulse(1'b1);
        for (int i = 0; i < 100 && state_o != 4'd4; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        check(state_o == 4'd4 && phase_o == 2'd1 && busy, "R7 off waits for ack",
              int'(phase_o), 1);
        pwr_good = 1'b0;
        @(negedge clk);
        check(done && phase_o == 2'd2, "R7 off settles on ack", int'(phase_o), 2);
        pulse(1'b0);
        repeat (9) @(negedge clk);
        check(state_o == 4'd5 && pwr_en, "R7 pwrup waits for ack", int'(state_o), 5);
        pwr_good = 1'b1;
        @(negedge clk);
        check(state_o == 4'd6, "R7 pwrup ends on ack", int'(state_o), 6);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(state_o == 4'd0 && done, "R7 back on", int'(state_o), 0);
        cfg_use_ack = 1'b0;
        @(negedge clk);
    endtask

    // R8: opposite requests are held, then acted on
    task automatic t_pending();
        cfg_settle = 8'd4; cfg_clk_stop = 1'b0;
        pulse(1'b1);
        pulse(1'b0);
        check(state_o == 4'd1, "R8 up request does not abort down", int'(state_o), 1);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(done && phase_o == 2'd2, "R8 off reached first", int'(phase_o), 2);
        @(negedge clk);
        check(state_o == 4'd5, "R8 held up starts power-up", int'(state_o), 5);
        pulse(1'b1);
        check(state_o == 4'd5 || state_o == 4'd6, "R8 down request does not abort up",
              int'(state_o), 5);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(done && state_o == 4'd0, "R8 on reached first", int'(state_o), 0);
        @(negedge clk);
        check(state_o == 4'd1, "R8 held down starts power-down", int'(state_o), 1);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        pulse(1'b0);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(state_o == 4'd0 && !busy, "R8 no stale hold after return", int'(state_o), 0);
    endtask

    // R11: same-direction requests at rest are ignored
    task automatic t_ignore();
        pulse(1'b0);
        repeat (3) @(negedge clk);
        check(state_o == 4'd0 && out_vec() == 5'b10001 && !busy,
              "R11 up request in ON ignored", int'(state_o), 0);
        cfg_settle = 8'd3;
        run_seq(1'b1, 1'b0, 3, 1, 3, 4, 0, 0, 3, "down before ignore");
        pulse(1'b1);
        repeat (3) @(negedge clk);
        check(phase_o == 2'd2 && !pwr_en && !busy, "R11 down request in OFF ignored",
              int'(phase_o), 2);
        run_seq(1'b0, 1'b0, 3, 5, 6, 8, 0, 0, 4, "up after ignore");
        repeat (3) @(negedge clk);
        check(state_o == 4'd0, "R11 ignored down left no hold", int'(state_o), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_down = 1'b0; req_up = 1'b0;
        cfg_clk_stop = 1'b0; cfg_use_ack = 1'b0; cfg_settle = 8'd4; pwr_good = 1'b1;
        t_reset();
        t_cycle_stop();
        t_cycle_nostop();
        t_settle();
        t_ack();
        t_pending();
        t_ignore();
        check(unsafe_cycles == 0, "R5 power off without isolation/retention",
              unsafe_cycles, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule